// File: doc/BRIEF.md
# Static LCD Segment Driver for a 3½-Digit Reading

This block turns a stored reading into drive levels for a direct-drive liquid crystal panel with one backplane. A reading has three BCD digits (ones, tens, hundreds), a flag for the leading half digit and a minus flag. The block holds the reading in a register and loads a new value only on a one-cycle load strobe, so the display keeps showing the previous result while the next conversion runs.

A counter divides the oscillator clock into a backplane square wave with an even duty cycle. Each segment output is the backplane itself when the segment is dark, and the inverse of the backplane when the segment is lit. This keeps the average DC across every segment at zero. A lamp-test input overrides this scheme and drives every segment pin to a steady high level, so the glass shows "-1888".

The digit count and the backplane half-period are parameters. With the default half-period of 400 cycles, the backplane runs at the clock rate divided by 800.

Top module: `lcd_static_drv`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `bp_out` is low. The stored reading is zero with both flags clear, so each digit shows "0" and `half_out` and `sign_out` match `bp_out`.
- R2: `bp_out` rises for the first time 400 clock edges after reset is released (with `DIV_HALF`=400). After that it stays high for exactly 400 cycles and low for exactly 400 cycles, repeating.
- R3: Outside lamp test, every dark segment output equals `bp_out`, and every lit segment output equals the inverse of `bp_out`, in both backplane phases.
- R4: Each digit maps to lit segments in the order {a,b,c,d,e,f,g}, with a as the most significant bit. The patterns are 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F, 9=7B (hex).
- R5: A digit code from 10 to 15 lights no segment, so that digit is blank.
- R6: `half_out` is lit when the stored half-digit flag is 1. `sign_out` is lit when the stored minus flag is 1. Each is dark when its flag is 0.
- R7: When `load` is high at a clock edge, `bcd_in`, `half_in` and `neg_in` are stored at that edge and shown from the next cycle on. When `load` is low, changes on those inputs have no effect on any output.
- R8: While `lamp_test` is high, `seg_out`, `half_out` and `sign_out` are all held constant at 1, whatever the phase of `bp_out`. When `lamp_test` is released, the stored reading is shown again, and the stored value has not changed.
- R9: In `seg_out`, bits [6:0] carry the ones digit, bits [13:7] the tens digit and bits [20:14] the hundreds digit. Within each group, the top bit is segment a and the bottom bit is segment g.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-cycle strobe that stores a new reading |
| bcd_in | input | 12 | BCD digits: hundreds [11:8], tens [7:4], ones [3:0] |
| half_in | input | 1 | Leading half digit "1" present |
| neg_in | input | 1 | Reading is negative |
| lamp_test | input | 1 | Force every segment on with a steady level |
| bp_out | output | 1 | Backplane square wave |
| seg_out | output | 21 | Segment drive for the three full digits |
| half_out | output | 1 | Shared drive for segments b and c of the half digit |
| sign_out | output | 1 | Minus sign drive |

## Verification
The bench counts the cycles to the first backplane edge and the length of each half period. An off-by-one in the divider compare would show up as 399 or 401 cycles. It checks every glyph in every digit position in both backplane phases. A swapped bit order, a swapped digit order, or a segment that ignores the phase would each break the expected XOR against the observed backplane. It changes the inputs without a load and expects the display to stay the same. It also loads codes above 9, which a naive decoder would show as garbage. Lamp test is checked across a backplane toggle, to catch a design that keeps toggling segments or that loses the stored reading.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

   typedef logic [6:0] seg7_t;   // {a,b,c,d,e,f,g}

   function automatic seg7_t bcd_glyph(input logic [3:0] code);
      seg7_t g;
      case (code)
         4'd0:    g = 7'b1111110;
         4'd1:    g = 7'b0110000;
         4'd2:    g = 7'b1101101;
         4'd3:    g = 7'b1111001;
         4'd4:    g = 7'b0110011;
         4'd5:    g = 7'b1011011;
         4'd6:    g = 7'b1011111;
         4'd7:    g = 7'b1110000;
         4'd8:    g = 7'b1111111;
         4'd9:    g = 7'b1111011;
         default: g = 7'b0000000;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/lcd_bp_div.sv
module lcd_bp_div #(
   parameter int DIV_HALF = 400
) (
   input  logic clk,
   input  logic rst,
   output logic bp
);
   localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

   generate
      if (DIV_HALF < 2) begin : g_bad_div
         $error("lcd_bp_div: DIV_HALF must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         bp  <= 1'b0;
      end else if (cnt == LAST) begin
         cnt <= '0;
         bp  <= ~bp;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R2: counter never leaves its range
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST);
   // R2: backplane only changes at the end of a half period
   p_bp_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (cnt != LAST) |=> $stable(bp));
   // R1: backplane starts low after reset
   p_bp_reset_r1: assert property (@(posedge clk)
      rst |=> !bp);
endmodule

// File: rtl/lcd_rd_latch.sv
module lcd_rd_latch #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("lcd_rd_latch: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end

   // R7: stored reading holds without a strobe
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));
   // R7: strobe captures the input
   p_capture_r7: assert property (@(posedge clk) disable iff (rst)
      load |=> q == $past(d));
endmodule

// File: rtl/lcd_phase_drv.sv
module lcd_phase_drv #(
   parameter int   W          = 23,
   parameter logic LAMP_LEVEL = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] lit,
   input  logic         bp,
   input  logic         lamp,
   output logic [W-1:0] drv
);
   generate
      if (W < 1) begin : g_bad_w
         $error("lcd_phase_drv: W must be positive");
      end
   endgenerate

   always_comb begin
      if (lamp) drv = {W{LAMP_LEVEL}};
      else      drv = lit ^ {W{bp}};
   end

   // R3: with a steady pattern, every pin flips when the backplane flips
   p_antiphase_r3: assert property (@(posedge clk) disable iff (rst)
      (!lamp && $past(!lamp) && (bp != $past(bp)) && $stable(lit))
      |-> (drv == ~$past(drv)));
   // R8: lamp test gives a DC level on every pin
   p_lamp_dc_r8: assert property (@(posedge clk) disable iff (rst)
      (lamp && $past(lamp)) |-> $stable(drv));
endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
   import lcd_drv_pkg::*;
#(
   parameter int NDIG     = 3,
   parameter int DIV_HALF = 400
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [4*NDIG-1:0] bcd_in,
   input  logic              half_in,
   input  logic              neg_in,
   input  logic              lamp_test,
   output logic              bp_out,
   output logic [7*NDIG-1:0] seg_out,
   output logic              half_out,
   output logic              sign_out
);
   localparam int BW = 4 * NDIG;
   localparam int SW = 7 * NDIG;
   localparam int LW = BW + 2;   // stored word: {neg, half, bcd}
   localparam int DW = SW + 2;   // drive word:  {sign, half, segs}

   generate
      if (NDIG < 1) begin : g_bad_ndig
         $error("lcd_static_drv: NDIG must be at least 1");
      end
   endgenerate

   logic          bp;
   logic [LW-1:0] stored;
   logic [SW-1:0] lit_seg;
   logic [DW-1:0] lit_all;
   logic [DW-1:0] drv_all;

   lcd_bp_div #(.DIV_HALF(DIV_HALF)) u_div (
      .clk (clk),
      .rst (rst),
      .bp  (bp)
   );

   lcd_rd_latch #(.W(LW)) u_latch (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .d    ({neg_in, half_in, bcd_in}),
      .q    (stored)
   );

   generate
      for (genvar i = 0; i < NDIG; i++) begin : g_dig
         assign lit_seg[7*i +: 7] = bcd_glyph(stored[4*i +: 4]);
      end
   endgenerate

   assign lit_all = {stored[BW+1], stored[BW], lit_seg};

   lcd_phase_drv #(.W(DW), .LAMP_LEVEL(1'b1)) u_drv (
      .clk  (clk),
      .rst  (rst),
      .lit  (lit_all),
      .bp   (bp),
      .lamp (lamp_test),
      .drv  (drv_all)
   );

   assign bp_out   = bp;
   assign seg_out  = drv_all[SW-1:0];
   assign half_out = drv_all[SW];
   assign sign_out = drv_all[SW+1];

   // R8: lamp test lights every pin high
   p_lamp_all_r8: assert property (@(posedge clk) disable iff (rst)
      lamp_test |-> (&seg_out && half_out && sign_out));
   // R6: cleared flags leave half digit and sign dark
   p_flags_dark_r6: assert property (@(posedge clk) disable iff (rst)
      (!lamp_test && !stored[BW] && !stored[BW+1]) |->
         (half_out == bp_out && sign_out == bp_out));
endmodule

// File: tb/sim_lcd_static_drv.sv
module sim_lcd_static_drv;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        load = 1'b0;
   logic [11:0] bcd_in = '0;
   logic        half_in = 1'b0;
   logic        neg_in = 1'b0;
   logic        lamp_test = 1'b0;
   logic        bp_out;
   logic [20:0] seg_out;
   logic        half_out;
   logic        sign_out;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   lcd_static_drv u0 (
      .clk(clk), .rst(rst), .load(load), .bcd_in(bcd_in),
      .half_in(half_in), .neg_in(neg_in), .lamp_test(lamp_test),
      .bp_out(bp_out), .seg_out(seg_out), .half_out(half_out),
      .sign_out(sign_out)
   );

   function automatic logic [6:0] glyph(input logic [3:0] c);
      case (c)
         4'd0: return 7'h7E; 4'd1: return 7'h30; 4'd2: return 7'h6D;
         4'd3: return 7'h79; 4'd4: return 7'h33; 4'd5: return 7'h5B;
         4'd6: return 7'h5F; 4'd7: return 7'h70; 4'd8: return 7'h7F;
         4'd9: return 7'h7B; default: return 7'h00;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected drive for a reading, using the observed backplane phase
   task automatic check_disp(input string req, input logic [11:0] b, input logic h, input logic n);
      logic [22:0] lit;
      lit = {n, h, glyph(b[11:8]), glyph(b[7:4]), glyph(b[3:0])};
      check(req, {9'd0, sign_out, half_out, seg_out}, {9'd0, lit ^ {23{bp_out}}});
   endtask

   task automatic load_val(input logic [11:0] b, input logic h, input logic n);
      bcd_in = b; half_in = h; neg_in = n; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic wait_flip();
      logic b0;
      b0 = bp_out;
      while (bp_out == b0) @(negedge clk);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 bp low in reset", {31'd0, bp_out}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 bp low after reset", {31'd0, bp_out}, 32'd0);
      check_disp("R1 zero reading", 12'h000, 1'b0, 1'b0);
   endtask

   task automatic t_bp_timing();
      int n;
      n = 1;   // one edge already passed in t_reset
      while (!bp_out && n < 2000) begin @(negedge clk); n++; end
      check("R2 first rise", n, 400);
      n = 0;
      while (bp_out && n < 2000) begin @(negedge clk); n++; end
      check("R2 high time", n, 400);
      n = 0;
      while (!bp_out && n < 2000) begin @(negedge clk); n++; end
      check("R2 low time", n, 400);
   endtask

   task automatic t_glyphs();
      for (int d = 0; d < 10; d++) begin
         logic [11:0] b;
         b = {4'(d), 4'((d + 3) % 10), 4'((d + 7) % 10)};
         load_val(b, 1'b0, 1'b0);
         check_disp("R4 R9 glyphs", b, 1'b0, 1'b0);
      end
      load_val(12'h182, 1'b0, 1'b0);
      check("R9 ones digit bits", {25'd0, seg_out[6:0] ^ {7{bp_out}}}, 32'h6D);
      check("R9 hundreds digit bits", {25'd0, seg_out[20:14] ^ {7{bp_out}}}, 32'h30);
      check_disp("R3 phase A", 12'h182, 1'b0, 1'b0);
      wait_flip();
      check_disp("R3 phase B", 12'h182, 1'b0, 1'b0);
   endtask

   task automatic t_invalid();
      load_val(12'hAF5, 1'b0, 1'b0);
      check("R5 blank code", {11'd0, seg_out[20:7] ^ {14{bp_out}}}, 32'd0);
      load_val(12'h9BC, 1'b0, 1'b0);
      check_disp("R5 blank codes", 12'h9BC, 1'b0, 1'b0);
   endtask

   task automatic t_flags();
      load_val(12'h999, 1'b1, 1'b1);
      check_disp("R6 half and sign on", 12'h999, 1'b1, 1'b1);
      load_val(12'h123, 1'b1, 1'b0);
      check_disp("R6 half only", 12'h123, 1'b1, 1'b0);
      load_val(12'h456, 1'b0, 1'b1);
      check_disp("R6 sign only", 12'h456, 1'b0, 1'b1);
      wait_flip();
      check_disp("R3 R6 flags other phase", 12'h456, 1'b0, 1'b1);
   endtask

   task automatic t_hold();
      load_val(12'h307, 1'b1, 1'b0);
      bcd_in = 12'h888; half_in = 1'b0; neg_in = 1'b1;
      repeat (5) @(negedge clk);
      check_disp("R7 no load keeps reading", 12'h307, 1'b1, 1'b0);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      check_disp("R7 load shows next cycle", 12'h888, 1'b0, 1'b1);
   endtask

   task automatic t_lamp();
      load_val(12'h250, 1'b0, 1'b0);
      lamp_test = 1'b1;
      @(negedge clk);
      check("R8 lamp all on", {9'd0, sign_out, half_out, seg_out}, {9'd0, {23{1'b1}}});
      wait_flip();
      check("R8 lamp steady across bp", {9'd0, sign_out, half_out, seg_out}, {9'd0, {23{1'b1}}});
      lamp_test = 1'b0;
      @(negedge clk);
      check_disp("R8 reading back after lamp", 12'h250, 1'b0, 1'b0);
   endtask

   initial begin
      #(200000 * 8);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_bp_timing();
      t_glyphs();
      t_invalid();
      t_flags();
      t_hold();
      t_lamp();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule